// File: doc/BRIEF.md
# Phase-Accumulator Waveform Core

This block is a synchronous numerically controlled oscillator. A 28-bit phase accumulator advances by a frequency word on every clock, and the output frequency is `word * f_clk / 2^28`. At a 25 MHz clock, for example, the word 0x8000000 gives 12.5 MHz. The accumulator has two frequency-word inputs and the phase mapping has two 12-bit phase-offset inputs. One bit of a 16-bit control word picks the frequency word and another picks the offset. The selected offset is added to the top 12 bits of the accumulator. The sum is then mapped to a 10-bit offset-binary sample.

The control word selects one of these shapes:
- a sine, read from a 256-entry quarter-wave table that is generated in the RTL;
- a folded triangle;
- a square taken from the phase MSB, at full or half amplitude.

Further control bits hold the accumulator at zero, freeze it, or blank the output. The control word and the four data words come from a register decoder elsewhere on the chip. The sample stream goes to a DAC interface, together with a valid strobe.

Top module: `dds_wave_core`

## Requirements
- R1: While control bits 8 and 7 are both 0, the accumulator grows by the selected frequency word on every clock, modulo 2^28. A sample leaves the output register three clocks after the accumulator value it was computed from.
- R2: Control bit 11 selects the frequency word: 1 selects `freq_b_i` and 0 selects `freq_a_i`.
- R3: Control bit 10 selects the phase offset: 1 selects `phase_b_i` and 0 selects `phase_a_i`. The mapped phase is the sum, modulo 2^12, of accumulator bits 27..16 and the selected offset.
- R4: Sine is selected when bit 5 = 0 and bit 1 = 0. With phase p, the table index is i = p[9:2], inverted when p[10] = 1. The magnitude is m = round(511*sin((2i+1)*pi/1024)). The sample is 512+m when p[11] = 0 and 511-m when p[11] = 1.
- R5: Triangle is selected when bit 5 = 0 and bit 1 = 1. With t = p[11:1], the sample is t[9:0] when t[10] = 0 and the inverse of t[9:0] when t[10] = 1.
- R6: Square is selected when bit 5 = 1. The sample is 0 when p[11] = 0. When p[11] = 1 the sample is 1023 if bit 3 = 1 and 511 if bit 3 = 0.
- R7: Bit 5 takes priority over bit 1. With both set, the output is square.
- R8: While control bit 8 is 1, the accumulator is held at zero, so the output is the mapping of the offset alone. When bit 8 returns to 0, counting restarts from zero.
- R9: While control bit 7 is 1 and bit 8 is 0, the accumulator keeps its value, so the output stays constant.
- R10: While control bit 6 is 1, samples are forced to 0 with the valid strobe low, and the accumulator keeps running. Any sample whose valid strobe is low is 0.
- R11: While `rst` is high, the sample is 0 and valid is low. After `rst` falls, valid rises with the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 16 | Control word: bit 11 frequency select, bit 10 offset select, bit 8 hold, bit 7 freeze, bit 6 blank, bit 5 square, bit 3 square full amplitude, bit 1 triangle |
| freq_a_i | input | 28 | Frequency word A |
| freq_b_i | input | 28 | Frequency word B |
| phase_a_i | input | 12 | Phase offset A |
| phase_b_i | input | 12 | Phase offset B |
| sample_o | output | 10 | Offset-binary waveform sample |
| sample_vld_o | output | 1 | Sample valid strobe |

## Verification
The checker watches the accumulator on every cycle. It checks that the accumulator steps by the selected word, that it returns to zero under hold, and that it stays put under freeze. It also checks that a sample whose valid strobe is low is zero.

The shape mappings cannot be shown by a per-cycle property; only the bench's scenarios show them:
- the sine table values and their quadrant folding;
- the triangle fold;
- the two square amplitudes;
- the priority between the mode bits;
- the three-cycle alignment between accumulator and sample.

The bench compares each of these against an independent phase model. The bench also shows that the accumulator keeps counting through a blanked stretch.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int CTRL_W    = 16;
  localparam int CB_FSEL   = 11;
  localparam int CB_PSEL   = 10;
  localparam int CB_HOLD   = 8;
  localparam int CB_STOP   = 7;
  localparam int CB_BLANK  = 6;
  localparam int CB_SQR    = 5;
  localparam int CB_SQFULL = 3;
  localparam int CB_TRI    = 1;

  typedef enum logic [1:0] {
    SHP_SINE    = 2'd0,
    SHP_TRI     = 2'd1,
    SHP_SQ_FULL = 2'd2,
    SHP_SQ_HALF = 2'd3
  } shape_e;

  // Square wins over triangle; sine when neither is set.
  function automatic shape_e decode_shape(input logic [CTRL_W-1:0] c);
    shape_e s;
    if (c[CB_SQR])      s = c[CB_SQFULL] ? SHP_SQ_FULL : SHP_SQ_HALF;
    else if (c[CB_TRI]) s = SHP_TRI;
    else                s = SHP_SINE;
    return s;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ACC_W-1:0]  freq_a_i,
  input  logic [ACC_W-1:0]  freq_b_i,
  input  logic [PH_W-1:0]   phase_a_i,
  input  logic [PH_W-1:0]   phase_b_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [PH_W-1:0]   ph_o,
  output shape_e            shape_o,
  output logic              blank_o,
  output logic              vld_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step_w;
  logic [PH_W-1:0]  off_w;

  assign step_w = ctrl_i[CB_FSEL] ? freq_b_i : freq_a_i;
  assign off_w  = ctrl_i[CB_PSEL] ? phase_b_i : phase_a_i;

  // Hold has priority over freeze.
  always_ff @(posedge clk) begin
    if (rst || ctrl_i[CB_HOLD]) begin
      acc_q <= '0;
    end else if (!ctrl_i[CB_STOP]) begin
      acc_q <= acc_q + step_w;
    end
  end

  // Stage 1: truncate and offset the phase, capture mode fields with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_o    <= '0;
      shape_o <= SHP_SINE;
      blank_o <= 1'b1;
      vld_o   <= 1'b0;
    end else begin
      ph_o    <= acc_q[ACC_W-1 -: PH_W] + off_w;
      shape_o <= decode_shape(ctrl_i);
      blank_o <= ctrl_i[CB_BLANK];
      vld_o   <= 1'b1;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);

  localparam int  DEPTH = 1 << AW;
  localparam real AMP   = real'((1 << DW) - 1);
  localparam real PI    = 3.141592653589793;

  logic [DW-1:0] mem [DEPTH];

  // Quarter wave sampled at half-step offsets, so that folding needs no endpoint fixup.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'($rtoi(AMP * $sin((2.0 * real'(i) + 1.0) * PI / (4.0 * real'(DEPTH))) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    data_o <= mem[addr_i];
  end

endmodule

// File: rtl/dds_shaper.sv
module dds_shaper
  import dds_pkg::*;
#(
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  ph_i,
  input  shape_e           shape_i,
  input  logic             blank_i,
  input  logic             vld_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             vld_o
);

  localparam int MID   = 1 << (OUT_W - 1);
  localparam int MAG_W = OUT_W - 1;

  logic [1:0]        quad_w;
  logic [LUT_AW-1:0] idx_w;
  logic [OUT_W:0]    tri_w;
  logic [MAG_W-1:0]  mag_w;

  assign quad_w = ph_i[PH_W-1 -: 2];
  assign idx_w  = quad_w[0] ? ~ph_i[PH_W-3 -: LUT_AW] : ph_i[PH_W-3 -: LUT_AW];
  assign tri_w  = ph_i[PH_W-1 -: OUT_W+1];

  dds_sine_rom #(
    .AW (LUT_AW),
    .DW (MAG_W)
  ) u_rom (
    .clk    (clk),
    .addr_i (idx_w),
    .data_o (mag_w)
  );

  // Stage 2: side data that travels with the table read.
  logic             neg_q;
  logic             sq_hi_q;
  logic [OUT_W-1:0] tri_q;
  shape_e           shape_q;
  logic             blank_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q   <= 1'b0;
      sq_hi_q <= 1'b0;
      tri_q   <= '0;
      shape_q <= SHP_SINE;
      blank_q <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      neg_q   <= quad_w[1];
      sq_hi_q <= ph_i[PH_W-1];
      tri_q   <= tri_w[OUT_W] ? ~tri_w[OUT_W-1:0] : tri_w[OUT_W-1:0];
      shape_q <= shape_i;
      blank_q <= blank_i;
      vld_q   <= vld_i;
    end
  end

  logic [OUT_W-1:0] sine_w;
  logic [OUT_W-1:0] wave_w;

  assign sine_w = neg_q ? (OUT_W'(MID - 1) - {1'b0, mag_w})
                        : (OUT_W'(MID) + {1'b0, mag_w});

  always_comb begin
    unique case (shape_q)
      SHP_SINE:    wave_w = sine_w;
      SHP_TRI:     wave_w = tri_q;
      SHP_SQ_FULL: wave_w = sq_hi_q ? '1 : '0;
      SHP_SQ_HALF: wave_w = sq_hi_q ? OUT_W'(MID - 1) : '0;
      default:     wave_w = '0;
    endcase
  end

  // Stage 3: registered output, zero whenever not valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o    <= vld_q & ~blank_q;
      sample_o <= (vld_q & ~blank_q) ? wave_w : '0;
    end
  end

endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core
  import dds_pkg::*;
#(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ACC_W-1:0]  freq_a_i,
  input  logic [ACC_W-1:0]  freq_b_i,
  input  logic [PH_W-1:0]   phase_a_i,
  input  logic [PH_W-1:0]   phase_b_i,
  output logic [OUT_W-1:0]  sample_o,
  output logic              sample_vld_o
);

  logic [ACC_W-1:0] acc_w;
  logic [PH_W-1:0]  ph_w;
  shape_e           shape_w;
  logic             blank_w;
  logic             vld_w;

  dds_phase_acc #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .ctrl_i    (ctrl_i),
    .freq_a_i  (freq_a_i),
    .freq_b_i  (freq_b_i),
    .phase_a_i (phase_a_i),
    .phase_b_i (phase_b_i),
    .acc_o     (acc_w),
    .ph_o      (ph_w),
    .shape_o   (shape_w),
    .blank_o   (blank_w),
    .vld_o     (vld_w)
  );

  dds_shaper #(
    .PH_W   (PH_W),
    .OUT_W  (OUT_W),
    .LUT_AW (LUT_AW)
  ) u_shape (
    .clk      (clk),
    .rst      (rst),
    .ph_i     (ph_w),
    .shape_i  (shape_w),
    .blank_i  (blank_w),
    .vld_i    (vld_w),
    .sample_o (sample_o),
    .vld_o    (sample_vld_o)
  );

endmodule

// File: rtl/dds_wave_core_chk.sv
module dds_wave_core_chk
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int OUT_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [ACC_W-1:0]  freq_a_i,
  input logic [ACC_W-1:0]  freq_b_i,
  input logic [ACC_W-1:0]  acc,
  input logic [OUT_W-1:0]  sample_o,
  input logic              sample_vld_o
);

  p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i[CB_HOLD] && !ctrl_i[CB_STOP]) |=>
      acc == ACC_W'($past(acc) + ($past(ctrl_i[CB_FSEL]) ? $past(freq_b_i) : $past(freq_a_i))));

  p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_i[CB_HOLD] |=> acc == '0);

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i[CB_STOP] && !ctrl_i[CB_HOLD]) |=> $stable(acc));

  p_blank_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !sample_vld_o |-> sample_o == '0);

endmodule

bind dds_wave_core dds_wave_core_chk #(
  .ACC_W (ACC_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctrl_i       (ctrl_i),
  .freq_a_i     (freq_a_i),
  .freq_b_i     (freq_b_i),
  .acc          (acc_w),
  .sample_o     (sample_o),
  .sample_vld_o (sample_vld_o)
);

// File: tb/test_dds_wave_core.sv
`timescale 1ns/1ps
module test_dds_wave_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl_i = '0;
  logic [27:0] freq_a_i = '0, freq_b_i = '0;
  logic [11:0] phase_a_i = '0, phase_b_i = '0;
  logic [9:0]  sample_o;
  logic        sample_vld_o;

  int total = 0;
  int bad   = 0;
  int kcnt  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dds_wave_core i_dds_wave_core (
    .clk          (clk),
    .rst          (rst),
    .ctrl_i       (ctrl_i),
    .freq_a_i     (freq_a_i),
    .freq_b_i     (freq_b_i),
    .phase_a_i    (phase_a_i),
    .phase_b_i    (phase_b_i),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o)
  );

  typedef struct packed {
    logic [27:0] fa;
    logic [27:0] fb;
    logic [11:0] pa;
    logic [11:0] pb;
    logic [15:0] c;
    logic [7:0]  k;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{28'h0100000, 28'h0000000, 12'h000, 12'h000, 16'h0000, 8'd40},  // R4 sine
    '{28'h0345678, 28'h0000000, 12'h123, 12'h000, 16'h0002, 8'd40},  // R5 triangle
    '{28'h0800000, 28'h0000000, 12'h000, 12'h000, 16'h0028, 8'd20},  // R6 square full
    '{28'h0800000, 28'h0000000, 12'h000, 12'h000, 16'h0020, 8'd20},  // R6 square half
    '{28'h0000000, 28'h0234567, 12'h000, 12'h000, 16'h0800, 8'd30},  // R2 word B
    '{28'h0100000, 28'h0000000, 12'h000, 12'h400, 16'h0400, 8'd30},  // R3 offset B
    '{28'h0900000, 28'h0000000, 12'h000, 12'h000, 16'h002A, 8'd20},  // R7 priority
    '{28'h8000000, 28'h0000000, 12'h010, 12'h000, 16'h0000, 8'd12},  // R1 half-rate word
    '{28'h0FEDCBA, 28'h0000000, 12'hFFF, 12'h000, 16'h0000, 8'd60}   // R4 wrapping offset
  };

  function automatic logic [9:0] model(input logic [11:0] ph, input logic [15:0] c);
    logic [7:0]  i;
    logic [10:0] t;
    int          mag;
    if (c[6]) return 10'd0;
    if (c[5]) return ph[11] ? (c[3] ? 10'd1023 : 10'd511) : 10'd0;
    if (c[1]) begin
      t = ph[11:1];
      return t[10] ? ~t[9:0] : t[9:0];
    end
    i   = ph[10] ? ~ph[9:2] : ph[9:2];
    mag = $rtoi(511.0 * $sin((2.0 * real'(i) + 1.0) * 3.141592653589793 / 1024.0) + 0.5);
    return ph[11] ? 10'(511 - mag) : 10'(512 + mag);
  endfunction

  function automatic logic [11:0] phase_at(input int k);
    logic [27:0] f;
    logic [27:0] a;
    logic [11:0] off;
    f   = ctrl_i[11] ? freq_b_i : freq_a_i;
    off = ctrl_i[10] ? phase_b_i : phase_a_i;
    a   = 28'(longint'(k) * longint'(f));
    return a[27:16] + off;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Load inputs under hold, check the held output, then release.
  task automatic start(input vec_t v);
    @(negedge clk);
    freq_a_i = v.fa; freq_b_i = v.fb; phase_a_i = v.pa; phase_b_i = v.pb;
    ctrl_i   = v.c | 16'h0100;
    repeat (5) @(negedge clk);
    chk(sample_o == model(phase_at(0), ctrl_i), "R8 hold", sample_o, model(phase_at(0), ctrl_i));
    ctrl_i = v.c;
    kcnt   = 0;
  endtask

  task automatic step_chk(input string req);
    @(negedge clk);
    kcnt++;
    if (kcnt >= 3) begin
      chk(sample_o == model(phase_at(kcnt - 3), ctrl_i) && sample_vld_o, req,
          sample_o, model(phase_at(kcnt - 3), ctrl_i));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    // R11 reset state
    repeat (4) @(negedge clk);
    chk(sample_o == 10'd0 && !sample_vld_o, "R11 reset", sample_o, 0);
    // R11 valid latency from reset release
    freq_a_i = 28'h0100000;
    rst = 1'b0;
    @(negedge clk);
    chk(!sample_vld_o, "R11 edge1", sample_vld_o, 0);
    @(negedge clk);
    chk(!sample_vld_o, "R11 edge2", sample_vld_o, 0);
    @(negedge clk);
    chk(sample_vld_o, "R11 edge3", sample_vld_o, 1);
    chk(sample_o == 10'd514, "R4 phase zero", sample_o, 514);

    // Vector table walk (R1..R7)
    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      start(v);
      for (int k = 0; k < int'(v.k); k++) step_chk($sformatf("R1 vec%0d", n));
    end

    // R9 freeze
    v = '{28'h0123456, 28'h0, 12'h000, 12'h000, 16'h0000, 8'd0};
    start(v);
    for (int k = 0; k < 10; k++) step_chk("R1 pre-freeze");
    ctrl_i[7] = 1'b1;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(sample_o == model(phase_at(10), ctrl_i), "R9 freeze", sample_o, model(phase_at(10), ctrl_i));
    end
    ctrl_i[7] = 1'b0;

    // R10 blank, accumulator keeps counting
    v = '{28'h0234567, 28'h0, 12'h000, 12'h000, 16'h0002, 8'd0};
    start(v);
    for (int k = 0; k < 8; k++) step_chk("R1 pre-blank");
    ctrl_i[6] = 1'b1;
    repeat (2) begin @(negedge clk); kcnt++; end
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); kcnt++;
      chk(sample_o == 10'd0 && !sample_vld_o, "R10 blanked", sample_o, 0);
    end
    ctrl_i[6] = 1'b0;
    repeat (2) begin @(negedge clk); kcnt++; end
    for (int k = 0; k < 3; k++) step_chk("R10 resume");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule